// File: doc/BRIEF.md
# Multi-Channel Pulse-Width Modulator Bank

This block is a bank of independent pulse-width modulator channels. Each channel drives one output pin. Software programs the channels through a small memory-mapped register interface. For each channel, a period count and an active-time count are written into holding registers. These values move into the running counter only after software writes the control register with its run bit set. The copy happens at the end of the period in progress, so no cut-short cycle reaches the pin. A second bit inverts the output. A third bit picks continuous repetition or a single period per start.

The bus uses byte addresses and works in words: the two lowest address bits are ignored. A read returns its data in the cycle after the request, and the data holds until the next read. Counting uses the bus clock directly, one tick per cycle. The number of channels is a parameter.

Top module: `pwm_bank`

## Requirements
- R1: After reset, every register reads 0 and every output is 0.
- R2: Channel c owns byte window c*0x20. The period register sits at +0x0, duty at +0x4, auxiliary at +0x8 and control at +0xC. A read returns the last written value one cycle after the request, and that value is held until the next read. In control, bit 0 is run, bit 1 is invert and bit 2 is repeat. Control bits 31..3 read 0.
- R3: Offsets 0x10..0x1C inside a window, and windows of channels at or above the channel count, read 0. Writes there change no register.
- R4: A running channel with repeat set, period P and duty D (0 < D < P) repeats every P cycles and is active for D cycles of each period.
- R5: A duty of 0 keeps the output inactive. A duty at or above the period keeps it active.
- R6: With invert set, the active level is 0 and the inactive level is 1.
- R7: With run clear, the output sits at its inactive level and the channel's counter is cleared.
- R8: Writing control with run = 1 to a stopped channel loads the period and duty. The active phase reaches the pin on the second clock edge after the write edge.
- R9: Rewriting period or duty while a channel runs leaves the output unchanged. After a later control write with run = 1, the new values start at the next period boundary, and every period on the pin is a whole old period or a whole new period.
- R10: With repeat clear, a start produces exactly one period. The output then stays inactive until the next control write with run = 1.
- R11: Channels run independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counting clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access strobe, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address (bits 1..0 ignored) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| pwm_out | output | NCH | One registered output per channel |

## Verification
Two events can fall in the same cycle: a refresh request reaching a running channel, and that channel wrapping at the end of its period. In that cycle the design must load the new values at the wrap. It must not defer them, and it must not cut the period short. The bench provokes this case by sweeping the refresh write across every phase of a 6-cycle period, after aligning to a rising output edge, so that one of the positions lands on the wrap cycle. In each sweep position the bench checks two things. Every spacing between rising edges must be exactly the old or the new period. Every active run must be exactly the old or the new duty.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned WIN_LOG2 = 5;   // 0x20-byte window per channel

  // word offset inside a channel window (address bits 4..2)
  typedef enum logic [2:0] {
    SEL_PERIOD = 3'd0,
    SEL_DUTY   = 3'd1,
    SEL_AUX    = 3'd2,
    SEL_CTRL   = 3'd3
  } reg_sel_e;

  localparam int unsigned RUN_BIT    = 0;
  localparam int unsigned INVERT_BIT = 1;
  localparam int unsigned REPEAT_BIT = 2;
  localparam int unsigned CTRL_W     = 3;

  typedef struct packed {
    logic repeat_on;
    logic invert;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/pwm_bank_decode.sv
module pwm_bank_decode
  import pwm_bank_pkg::*;
#(
  parameter int unsigned NCH    = 4,
  parameter int unsigned ADDR_W = 8,
  localparam int unsigned CH_W  = ADDR_W - WIN_LOG2
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [CH_W-1:0]   dec_ch,
  output reg_sel_e          dec_sel,
  output logic              dec_hit
);
  logic ch_ok;

  always_comb begin
    dec_ch  = addr[ADDR_W-1:WIN_LOG2];
    dec_sel = reg_sel_e'(addr[WIN_LOG2-1:2]);
    ch_ok   = ({1'b0, dec_ch} < (CH_W+1)'(NCH));
    // upper half of each window (bit 4 set) holds no register
    dec_hit = ch_ok && !addr[WIN_LOG2-1];
  end
endmodule

// File: rtl/pwm_bank_regs.sv
module pwm_bank_regs
  import pwm_bank_pkg::*;
#(
  parameter int unsigned NCH    = 4,
  parameter int unsigned ADDR_W = 8,
  localparam int unsigned CH_W  = ADDR_W - WIN_LOG2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         acc_valid,
  input  logic                         acc_write,
  input  logic [CH_W-1:0]              acc_ch,
  input  reg_sel_e                     acc_sel,
  input  logic                         acc_hit,
  input  logic [DATA_W-1:0]            acc_wdata,
  output logic [DATA_W-1:0]            acc_rdata,
  output logic [NCH-1:0][DATA_W-1:0]   shd_period,
  output logic [NCH-1:0][DATA_W-1:0]   shd_duty,
  output ctrl_t [NCH-1:0]              ctrl,
  output logic [NCH-1:0]               refresh
);
  logic [NCH-1:0][DATA_W-1:0] aux_q;
  logic [DATA_W-1:0]          rd_mux;
  logic                       wr_en;
  logic                       rd_en;

  assign wr_en = acc_valid && acc_write && acc_hit;
  assign rd_en = acc_valid && !acc_write;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic sel_me;
    assign sel_me = wr_en && (acc_ch == CH_W'(c));

    always_ff @(posedge clk) begin
      if (rst) begin
        shd_period[c] <= '0;
        shd_duty[c]   <= '0;
        aux_q[c]      <= '0;
        ctrl[c]       <= '0;
        refresh[c]    <= 1'b0;
      end else begin
        refresh[c] <= sel_me && (acc_sel == SEL_CTRL) && acc_wdata[RUN_BIT];
        if (sel_me) begin
          case (acc_sel)
            SEL_PERIOD: shd_period[c] <= acc_wdata;
            SEL_DUTY:   shd_duty[c]   <= acc_wdata;
            SEL_AUX:    aux_q[c]      <= acc_wdata;
            SEL_CTRL:   ctrl[c]       <= ctrl_t'(acc_wdata[CTRL_W-1:0]);
            default:    ;
          endcase
        end
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    for (int c = 0; c < NCH; c++) begin
      if (acc_hit && acc_ch == CH_W'(c)) begin
        case (acc_sel)
          SEL_PERIOD: rd_mux = shd_period[c];
          SEL_DUTY:   rd_mux = shd_duty[c];
          SEL_AUX:    rd_mux = aux_q[c];
          SEL_CTRL:   rd_mux = {{(DATA_W-CTRL_W){1'b0}}, ctrl[c]};
          default:    rd_mux = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        acc_rdata <= '0;
    else if (rd_en) acc_rdata <= rd_mux;
  end
endmodule

// File: rtl/pwm_bank_chan.sv
module pwm_bank_chan
  import pwm_bank_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  ctrl_t            ctrl,
  input  logic             refresh,
  input  logic [CNT_W-1:0] shd_period,
  input  logic [CNT_W-1:0] shd_duty,
  output logic             running,
  output logic             pin
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] per_q;
  logic [CNT_W-1:0] duty_q;
  logic             pend_q;
  logic             wrap;
  logic             swap;
  logic             active;

  // 33-bit compare keeps a period of 0 or all-ones free of overflow
  assign wrap   = ({1'b0, cnt_q} + 1'b1) >= {1'b0, per_q};
  assign swap   = pend_q || refresh;
  assign active = (duty_q != '0) && (cnt_q < duty_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      cnt_q   <= '0;
      per_q   <= '0;
      duty_q  <= '0;
      pend_q  <= 1'b0;
    end else if (!ctrl.run) begin
      running <= 1'b0;
      cnt_q   <= '0;
      pend_q  <= 1'b0;
    end else if (!running) begin
      if (refresh) begin
        running <= 1'b1;
        cnt_q   <= '0;
        per_q   <= shd_period;
        duty_q  <= shd_duty;
        pend_q  <= 1'b0;
      end
    end else if (wrap) begin
      cnt_q <= '0;
      if (swap) begin
        per_q  <= shd_period;
        duty_q <= shd_duty;
        pend_q <= 1'b0;
      end else if (!ctrl.repeat_on) begin
        running <= 1'b0;
      end
    end else begin
      cnt_q <= cnt_q + 1'b1;
      if (refresh) pend_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pin <= 1'b0;
    else     pin <= (running && active) ^ ctrl.invert;
  end
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
  import pwm_bank_pkg::*;
#(
  parameter int unsigned NCH    = 4,
  parameter int unsigned ADDR_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_valid,
  input  logic                bus_write,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic [NCH-1:0]      pwm_out
);
  localparam int unsigned CH_W = ADDR_W - WIN_LOG2;

  logic [CH_W-1:0]            dec_ch;
  reg_sel_e                   dec_sel;
  logic                       dec_hit;
  logic [NCH-1:0][DATA_W-1:0] shd_period;
  logic [NCH-1:0][DATA_W-1:0] shd_duty;
  ctrl_t [NCH-1:0]            ctrl;
  logic [NCH-1:0]             ch_refresh;
  logic [NCH-1:0]             ch_run;
  logic [NCH-1:0]             ch_en;
  logic [NCH-1:0]             ch_pol;

  pwm_bank_decode #(.NCH(NCH), .ADDR_W(ADDR_W)) u_dec (
    .addr    (bus_addr),
    .dec_ch  (dec_ch),
    .dec_sel (dec_sel),
    .dec_hit (dec_hit)
  );

  pwm_bank_regs #(.NCH(NCH), .ADDR_W(ADDR_W)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .acc_valid  (bus_valid),
    .acc_write  (bus_write),
    .acc_ch     (dec_ch),
    .acc_sel    (dec_sel),
    .acc_hit    (dec_hit),
    .acc_wdata  (bus_wdata),
    .acc_rdata  (bus_rdata),
    .shd_period (shd_period),
    .shd_duty   (shd_duty),
    .ctrl       (ctrl),
    .refresh    (ch_refresh)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    assign ch_en[c]  = ctrl[c].run;
    assign ch_pol[c] = ctrl[c].invert;

    pwm_bank_chan #(.CNT_W(DATA_W)) u_chan (
      .clk        (clk),
      .rst        (rst),
      .ctrl       (ctrl[c]),
      .refresh    (ch_refresh[c]),
      .shd_period (shd_period[c]),
      .shd_duty   (shd_duty[c]),
      .running    (ch_run[c]),
      .pin        (pwm_out[c])
    );
  end
endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk #(
  parameter int unsigned NCH    = 4,
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_rdata,
  input logic [NCH-1:0]    pwm_out,
  input logic [NCH-1:0]    ch_en,
  input logic [NCH-1:0]    ch_pol,
  input logic [NCH-1:0]    ch_refresh,
  input logic [NCH-1:0]    ch_run
);
  logic rd_req;
  logic unmapped;

  assign rd_req   = bus_valid && !bus_write;
  assign unmapped = bus_addr[4] ||
                    ({1'b0, bus_addr[ADDR_W-1:5]} >= (ADDR_W-4)'(NCH));

  assert_unmapped_read_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (rd_req && unmapped) |=> bus_rdata == 32'd0);

  assert_rdata_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !rd_req |=> $stable(bus_rdata));

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assert_stop_when_off_R7: assert property (@(posedge clk) disable iff (rst)
      !ch_en[c] |=> !ch_run[c]);

    assert_idle_level_R6: assert property (@(posedge clk) disable iff (rst)
      !ch_run[c] |=> pwm_out[c] == $past(ch_pol[c]));

    assert_start_on_refresh_R8: assert property (@(posedge clk) disable iff (rst)
      (ch_en[c] && !ch_run[c] && ch_refresh[c]) |=> ch_run[c]);
  end
endmodule

bind pwm_bank pwm_bank_chk #(.NCH(NCH), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/pwm_bank_tb.sv
module pwm_bank_tb;
  localparam int NCH    = 4;
  localparam int ADDR_W = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              bus_valid = 1'b0;
  logic              bus_write = 1'b0;
  logic [ADDR_W-1:0] bus_addr  = '0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic [NCH-1:0]    pwm_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  pwm_bank #(.NCH(NCH), .ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pwm_out(pwm_out)
  );

  function automatic logic [ADDR_W-1:0] ra(int ch, int off);
    return ADDR_W'(ch * 32 + off);
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic bus_wr(logic [ADDR_W-1:0] a, logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic bus_rd(logic [ADDR_W-1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wait_cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic count_high(int ch, int cycles, output int highs);
    highs = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (pwm_out[ch]) highs++;
    end
  endtask

  task automatic setup(int ch, int per, int duty, int ctrl_v);
    bus_wr(ra(ch, 'hC), 32'd0);
    bus_wr(ra(ch, 'h0), 32'(per));
    bus_wr(ra(ch, 'h4), 32'(duty));
    bus_wr(ra(ch, 'hC), 32'(ctrl_v));
  endtask

  // R1
  task automatic t_reset;
    logic [31:0] d;
    check(pwm_out == '0, "R1", "outputs after reset", pwm_out, 0);
    for (int c = 0; c < NCH; c++)
      for (int o = 0; o < 16; o += 4) begin
        bus_rd(ra(c, o), d);
        check(d == 0, "R1", "register after reset", d, 0);
      end
  endtask

  // R2, R3
  task automatic t_regs;
    logic [31:0] d;
    bus_wr(ra(1, 'h0), 32'hDEAD_BEEF);
    bus_wr(ra(1, 'h4), 32'h1234_5678);
    bus_wr(ra(1, 'h8), 32'hA5A5_0F0F);
    bus_wr(ra(1, 'hC), 32'hFFFF_FFF8);
    bus_rd(ra(1, 'h0), d); check(d == 32'hDEAD_BEEF, "R2", "period readback", d, 32'hDEAD_BEEF);
    bus_rd(ra(1, 'h4), d); check(d == 32'h1234_5678, "R2", "duty readback", d, 32'h1234_5678);
    bus_rd(ra(1, 'h8), d); check(d == 32'hA5A5_0F0F, "R2", "aux readback", d, 32'hA5A5_0F0F);
    bus_rd(ra(1, 'hC), d); check(d == 0, "R2", "ctrl upper bits read 0", d, 0);
    bus_wr(ra(1, 'hC), 32'h6);
    bus_rd(ra(1, 'hC), d); check(d == 6, "R2", "ctrl readback", d, 6);
    wait_cyc(3);
    check(bus_rdata == 6, "R2", "rdata held", bus_rdata, 6);
    bus_wr(ra(1, 'hC), 32'h0);
    bus_wr(ra(0, 'h10), 32'h1111_1111);
    bus_wr(ra(0, 'h1C), 32'h2222_2222);
    bus_wr(ra(NCH, 'h0), 32'h3333_3333);
    bus_rd(ra(0, 'h10), d); check(d == 0, "R3", "gap offset reads 0", d, 0);
    bus_rd(ra(NCH, 'h0), d); check(d == 0, "R3", "absent channel reads 0", d, 0);
    for (int o = 0; o < 16; o += 4) begin
      bus_rd(ra(0, o), d); check(d == 0, "R3", "ch0 untouched by stray write", d, 0);
    end
  endtask

  // R4, R7, R8
  task automatic t_basic;
    int h;
    logic [5:0] seq;
    setup(0, 10, 3, 5);
    wait_cyc(12);
    count_high(0, 50, h); check(h == 15, "R4", "active cycles 5x(P10,D3)", h, 15);
    bus_wr(ra(0, 'hC), 32'h0);
    wait_cyc(2);
    count_high(0, 12, h); check(h == 0, "R7", "disabled output low", h, 0);
    bus_wr(ra(0, 'hC), 32'h5);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); seq[i] = pwm_out[0];
    end
    check(seq == 6'b001110, "R8", "start timing 0,1,1,1,0,0 (lsb first)", seq, 6'b001110);
  endtask

  // R5
  task automatic t_extremes;
    int h;
    setup(3, 8, 8, 5);
    wait_cyc(4);
    count_high(3, 24, h); check(h == 24, "R5", "duty == period fully active", h, 24);
    bus_wr(ra(3, 'h4), 32'd100);
    bus_wr(ra(3, 'hC), 32'h5);
    wait_cyc(12);
    count_high(3, 24, h); check(h == 24, "R5", "duty > period fully active", h, 24);
    bus_wr(ra(3, 'h4), 32'd0);
    bus_wr(ra(3, 'hC), 32'h5);
    wait_cyc(12);
    count_high(3, 24, h); check(h == 0, "R5", "duty 0 fully inactive", h, 0);
    bus_wr(ra(3, 'hC), 32'h0);
  endtask

  // R6
  task automatic t_invert;
    int h;
    bus_wr(ra(2, 'hC), 32'h2);
    wait_cyc(2);
    count_high(2, 10, h); check(h == 10, "R6", "inverted idle level high", h, 10);
    setup(2, 10, 3, 7);
    wait_cyc(12);
    count_high(2, 30, h); check(h == 21, "R6", "inverted: 9 low of 30", h, 21);
    bus_wr(ra(2, 'hC), 32'h0);
  endtask

  // R10
  task automatic t_oneshot;
    int h;
    setup(1, 5, 2, 1);
    count_high(1, 30, h); check(h == 2, "R10", "single period then idle", h, 2);
    bus_wr(ra(1, 'hC), 32'h1);
    count_high(1, 30, h); check(h == 2, "R10", "restart gives one more period", h, 2);
    bus_wr(ra(1, 'hC), 32'h0);
  endtask

  // R11
  task automatic t_indep;
    int h0, h1;
    setup(0, 10, 5, 5);
    setup(1, 4, 1, 5);
    wait_cyc(12);
    h0 = 0; h1 = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (pwm_out[0]) h0++;
      if (pwm_out[1]) h1++;
    end
    check(h0 == 20, "R11", "ch0 alongside ch1", h0, 20);
    check(h1 == 10, "R11", "ch1 alongside ch0", h1, 10);
    bus_wr(ra(1, 'hC), 32'h0);
    count_high(0, 40, h0); check(h0 == 20, "R11", "ch0 unaffected by ch1 stop", h0, 20);
    bus_wr(ra(0, 'hC), 32'h0);
  endtask

  // R9: shadow hold, then refresh swept across every phase (one hits the wrap)
  task automatic t_refresh;
    int h;
    int bad, last_rise, run_len;
    bit prev, tracking;
    setup(0, 10, 3, 5);
    wait_cyc(12);
    bus_wr(ra(0, 'h0), 32'd20);
    bus_wr(ra(0, 'h4), 32'd7);
    count_high(0, 40, h); check(h == 12, "R9", "shadow not applied before refresh", h, 12);
    for (int off = 0; off < 6; off++) begin
      setup(0, 6, 2, 5);
      for (int i = 0; i < 20 && !pwm_out[0]; i++) @(negedge clk);
      bus_wr(ra(0, 'h0), 32'd8);
      bus_wr(ra(0, 'h4), 32'd4);
      wait_cyc(off);
      bus_wr(ra(0, 'hC), 32'h5);
      bad = 0; last_rise = -1; run_len = 0; tracking = 0; prev = pwm_out[0];
      for (int t = 0; t < 40; t++) begin
        @(negedge clk);
        if (pwm_out[0] && !prev) begin
          if (last_rise >= 0 && (t - last_rise) != 6 && (t - last_rise) != 8) bad++;
          last_rise = t; tracking = 1; run_len = 0;
        end
        if (pwm_out[0]) run_len++;
        if (!pwm_out[0] && prev && tracking && run_len != 2 && run_len != 4) bad++;
        prev = pwm_out[0];
      end
      check(bad == 0, "R9", $sformatf("whole periods only, refresh offset %0d", off), bad, 0);
      count_high(0, 16, h);
      check(h == 8, "R9", $sformatf("new values active, offset %0d", off), h, 8);
    end
    bus_wr(ra(0, 'hC), 32'h0);
  endtask

  initial begin
    wait_cyc(2000000 / 10 - 100);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    wait_cyc(4);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_regs();
    t_basic();
    t_extremes();
    t_invert();
    t_oneshot();
    t_indep();
    t_refresh();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule